// File: doc/BRIEF.md
# Two-Bit Serial Flash Read Engine

This block is the sequencer and datapath behind the two-bit-wide read commands of a serial NOR flash slave. An upstream single-bit command decoder recognises the opcode and hands over with one of two start strobes. In dual-output mode the engine takes a 24-bit address one bit per serial rising edge on pin 0, waits through eight dummy edges, and then streams data. In dual I/O mode it takes the address and an 8-bit mode byte two bits per rising edge, and data follows immediately. In both modes each byte is fetched from the memory array through a simple registered read port and sent out two bits per serial falling edge. The address advances after every byte until chip select rises.

The engine owns the output enables of both data pins. It holds them released through every input phase and turns them on only at the first output falling edge. It also keeps a continuous-read flag, which is decided by the mode byte. While the flag is set, the next transaction needs no opcode and no start strobe: address entry begins on the first rising edge after chip select falls. The serial clock arrives as one-cycle rise and fall strobes in the block's clock domain. These strobes, and the start strobes, are assumed to be at least four clock cycles apart.

Top module: `dread_engine`

## Requirements
- R1: In dual I/O mode the address is taken over 12 rising strobes, two bits each, most significant pair first. Pin 1 carries the odd bits (A23, A21, ..., A1) and pin 0 carries the even bits (A22, ..., A0). The low ARR_AW address bits select the first array byte.
- R2: In dual I/O mode, 4 more rising strobes carry the mode byte with the same odd/even pin split. There are no dummy edges: the first data bits appear on the next falling strobe.
- R3: In dual-output mode the address is taken over 24 rising strobes, one bit each on pin 0, MSB first, and pin 1 is ignored. Eight dummy rising strobes follow, and then data starts on the next falling strobe.
- R4: Each data falling strobe drives one bit pair, with pin 1 carrying bit 7, 5, 3, 1 and pin 0 carrying bit 6, 4, 2, 0. Bits 7/6 go out first, and four falling strobes make one byte.
- R5: After each byte the array address increments by one and wraps modulo 2^ARR_AW. Address bits above ARR_AW have no effect.
- R6: Both output enables are 0 from reset and through every command, address, mode and dummy edge. They become 1 together on the first data falling strobe and drop in the same cycle that cs_n goes high.
- R7: If mode bits 5:4 equal 2'b10, cont_active becomes 1 when the mode byte completes. The next transaction then starts address entry at its first rising strobe without any start strobe.
- R8: Any other value of mode bits 5:4 clears cont_active when the mode byte completes. Mode bits 7:6 and 3:0 have no effect on the flag.
- R9: cont_active is cleared by reset, and by cs_n rising while the address or mode phase is still incomplete.
- R10: arr_rd is a single-cycle pulse, and arr_rdata is taken on the following cycle. Each transaction of N bytes issues exactly N+1 reads: the first byte, plus one prefetch after each byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronised |
| sclk_rise | input | 1 | One-cycle strobe for a serial clock rising edge |
| sclk_fall | input | 1 | One-cycle strobe for a serial clock falling edge |
| start_dout | input | 1 | Decoder strobe: start a dual-output read |
| start_dio | input | 1 | Decoder strobe: start a dual I/O read |
| dq_in | input | 2 | Sampled data pins, bit 1 = pin 1 |
| dq_out | output | 2 | Output values for the data pins |
| dq_oe | output | 2 | Output enables for the data pins |
| cont_active | output | 1 | Continuous-read flag; the next transaction skips its opcode |
| arr_rd | output | 1 | Array read request |
| arr_addr | output | ARR_AW | Array byte address |
| arr_rdata | input | 8 | Array data, valid the cycle after arr_rd |

## Verification
The bench sweeps all 256 mode-byte values in succession. Each transaction uses or omits its opcode according to the flag the previous mode byte should have left. A design that decoded the wrong mode bits, or ignored the flag, would lose address alignment and return wrong bytes. Other transactions start at the top of the array to force address wrap, and some abort inside the address and mode phases. A design that kept the flag after an abort, or that let the upper address bits reach the array, would show a stale cont_active or bytes from the wrong location. The bench also toggles the falling strobe during every input phase and drives pin 1 high through the single-bit address and dummy edges. A design that drove the pins early, or that listened to pin 1 in dual-output mode, would fail the enable checks or fetch from a corrupted address.

// File: rtl/dread_pkg.sv
// Shared definitions for the two-bit read engine: sequencer state encoding,
// the mode code that arms continuous read, and the array data width.
package dread_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_MODE,
        ST_DUMMY,
        ST_DATA
    } dr_state_e;

    // Mode bits 5:4 value that lets the next transaction skip its opcode.
    localparam logic [1:0] CONT_CODE = 2'b10;

    localparam int DATA_BITS = 8;

endpackage

// File: rtl/dread_capture.sv
// Input shift register for address and mode bits.
// Shifts one bit (pin 0) or two bits (pin 1 is the older bit) per enable.
// Only the newest CAP_W bits are kept; older address bits fall off the top.
// Assumes the caller enables it only on rising strobes in the input phases.
module dread_capture #(
    parameter int CAP_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             wide,
    input  logic [1:0]       dq_in,
    output logic [CAP_W-1:0] cap_next
);

    logic [CAP_W-1:0] cap_q;

    // Next-state view, so the final edge's bits are usable in the same cycle.
    always_comb begin
        if (!shift_en)
            cap_next = cap_q;
        else if (wide)
            cap_next = {cap_q[CAP_W-3:0], dq_in};
        else
            cap_next = {cap_q[CAP_W-2:0], dq_in[0]};
    end

    // Holds the shifted bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_q <= '0;
        else
            cap_q <= cap_next;
    end

endmodule

// File: rtl/dread_seq.sv
// Phase sequencer for the two-bit reads. It tracks the address, mode, dummy
// and data phases, counts rising strobes, and owns the continuous-read flag.
// Assumes start strobes come from an external decoder after the opcode, and
// only while the flag is clear.
module dread_seq import dread_pkg::*; #(
    parameter int ADDR_BITS   = 24,
    parameter int MODE_BITS   = 8,
    parameter int DUMMY_EDGES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk_rise,
    input  logic       start_dout,
    input  logic       start_dio,
    input  logic [1:0] mode_sel,
    output logic       wide,
    output logic       shift_en,
    output logic       go_data,
    output logic       cont_q
);

    localparam int CNT_MAX = (ADDR_BITS > DUMMY_EDGES) ? ADDR_BITS : DUMMY_EDGES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(ADDR_BITS / 2 - 1);
    localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] MODE_LAST   = CNT_W'(MODE_BITS / 2 - 1);
    localparam logic [CNT_W-1:0] DUMMY_LAST  = CNT_W'(DUMMY_EDGES - 1);

    dr_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cs_q;
    logic             addr_done;
    logic             mode_done;
    logic             dummy_done;

    // Phase-end detection and strobe qualification.
    always_comb begin
        addr_done  = (state_q == ST_ADDR)  && (cnt_q == (wide ? WIDE_LAST : NARROW_LAST));
        mode_done  = (state_q == ST_MODE)  && (cnt_q == MODE_LAST);
        dummy_done = (state_q == ST_DUMMY) && (cnt_q == DUMMY_LAST);
        shift_en   = !cs_n && sclk_rise && ((state_q == ST_ADDR) || (state_q == ST_MODE));
        go_data    = !cs_n && sclk_rise && (mode_done || dummy_done);
    end

    // Phase state, edge counter, bus width and continuous-read flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wide    <= 1'b0;
            cont_q  <= 1'b0;
            cs_q    <= 1'b1;
        end else begin
            cs_q <= cs_n;
            if (cs_n) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
                if ((state_q == ST_ADDR) || (state_q == ST_MODE))
                    cont_q <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        cnt_q <= '0;
                        if (cs_q && cont_q) begin
                            state_q <= ST_ADDR;
                            wide    <= 1'b1;
                        end else if (!cont_q && start_dio) begin
                            state_q <= ST_ADDR;
                            wide    <= 1'b1;
                        end else if (!cont_q && start_dout) begin
                            state_q <= ST_ADDR;
                            wide    <= 1'b0;
                        end
                    end
                    ST_ADDR: begin
                        if (sclk_rise) begin
                            if (addr_done) begin
                                cnt_q   <= '0;
                                state_q <= wide ? ST_MODE : ST_DUMMY;
                            end else begin
                                cnt_q <= cnt_q + CNT_W'(1);
                            end
                        end
                    end
                    ST_MODE: begin
                        if (sclk_rise) begin
                            if (mode_done) begin
                                cnt_q   <= '0;
                                state_q <= ST_DATA;
                                cont_q  <= (mode_sel == CONT_CODE);
                            end else begin
                                cnt_q <= cnt_q + CNT_W'(1);
                            end
                        end
                    end
                    ST_DUMMY: begin
                        if (sclk_rise) begin
                            if (dummy_done) begin
                                cnt_q   <= '0;
                                state_q <= ST_DATA;
                            end else begin
                                cnt_q <= cnt_q + CNT_W'(1);
                            end
                        end
                    end
                    ST_DATA: state_q <= ST_DATA;
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/dread_tx.sv
// Output side: array fetch, byte shifter and pin enables.
// On load it reads the start byte. Each falling strobe sends the top bit
// pair, and after the last pair of a byte it prefetches the next address.
// Assumes strobes are at least four clocks apart, so the two-cycle fetch
// completes before the next falling strobe.
module dread_tx import dread_pkg::*; #(
    parameter int ARR_AW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sclk_fall,
    input  logic                 load,
    input  logic [ARR_AW-1:0]    load_addr,
    input  logic [DATA_BITS-1:0] arr_rdata,
    output logic                 arr_rd,
    output logic [ARR_AW-1:0]    arr_addr,
    output logic [1:0]           dq_out,
    output logic [1:0]           dq_oe
);

    localparam int PAIRS  = DATA_BITS / 2;
    localparam int PAIR_W = $clog2(PAIRS);
    localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(PAIRS - 1);

    logic                 active_q;
    logic                 oe_q;
    logic                 rd_q;
    logic                 fill_q;
    logic [ARR_AW-1:0]    addr_q;
    logic [DATA_BITS-1:0] sh_q;
    logic [PAIR_W-1:0]    pair_q;
    logic [1:0]           out_q;
    logic                 fall_go;
    logic                 byte_end;
    logic                 start_go;

    // Qualified events for this cycle.
    always_comb begin
        start_go = !cs_n && load;
        fall_go  = active_q && sclk_fall && !cs_n && !load;
        byte_end = fall_go && (pair_q == LAST_PAIR);
    end

    // Array fetch: address register, read pulse and fill marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            fill_q <= 1'b0;
            addr_q <= '0;
        end else begin
            fill_q <= rd_q;
            rd_q   <= start_go || byte_end;
            if (start_go)
                addr_q <= load_addr;
            else if (byte_end)
                addr_q <= addr_q + ARR_AW'(1);
        end
    end

    // Byte shifter and output pair register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            out_q  <= 2'b00;
            pair_q <= '0;
        end else begin
            if (fall_go)
                sh_q <= {sh_q[DATA_BITS-3:0], 2'b00};
            else if (fill_q)
                sh_q <= arr_rdata;
            if (cs_n || load) begin
                pair_q <= '0;
            end else if (fall_go) begin
                out_q  <= sh_q[DATA_BITS-1 -: 2];
                pair_q <= pair_q + PAIR_W'(1);
            end
        end
    end

    // Transfer activity and pin enable tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            oe_q     <= 1'b0;
        end else if (cs_n) begin
            active_q <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            if (load)
                active_q <= 1'b1;
            if (fall_go)
                oe_q <= 1'b1;
        end
    end

    assign arr_rd   = rd_q;
    assign arr_addr = addr_q;
    assign dq_out   = out_q;
    assign dq_oe    = {2{oe_q && !cs_n}};

endmodule

// File: rtl/dread_engine.sv
// Top of the two-bit serial flash read engine. It joins the input capture,
// the phase sequencer and the output/fetch path. Assumes MODE_BITS is 8,
// ADDR_BITS is even and ARR_AW <= ADDR_BITS. Serial edges arrive as
// one-cycle strobes synchronous to clk.
module dread_engine #(
    parameter int ADDR_BITS   = 24,
    parameter int MODE_BITS   = 8,
    parameter int DUMMY_EDGES = 8,
    parameter int ARR_AW      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              start_dout,
    input  logic              start_dio,
    input  logic [1:0]        dq_in,
    output logic [1:0]        dq_out,
    output logic [1:0]        dq_oe,
    output logic              cont_active,
    output logic              arr_rd,
    output logic [ARR_AW-1:0] arr_addr,
    input  logic [7:0]        arr_rdata
);

    localparam int CAP_W = MODE_BITS + ARR_AW;

    logic              wide;
    logic              shift_en;
    logic              go_data;
    logic [CAP_W-1:0]  cap_next;
    logic [ARR_AW-1:0] load_addr;

    dread_capture #(.CAP_W(CAP_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .wide     (wide),
        .dq_in    (dq_in),
        .cap_next (cap_next)
    );

    dread_seq #(
        .ADDR_BITS   (ADDR_BITS),
        .MODE_BITS   (MODE_BITS),
        .DUMMY_EDGES (DUMMY_EDGES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk_rise  (sclk_rise),
        .start_dout (start_dout),
        .start_dio  (start_dio),
        .mode_sel   (cap_next[5:4]),
        .wide       (wide),
        .shift_en   (shift_en),
        .go_data    (go_data),
        .cont_q     (cont_active)
    );

    // Start address: above the mode byte in dual I/O, lowest bits otherwise.
    always_comb begin
        if (wide)
            load_addr = cap_next[MODE_BITS +: ARR_AW];
        else
            load_addr = cap_next[ARR_AW-1:0];
    end

    dread_tx #(.ARR_AW(ARR_AW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk_fall (sclk_fall),
        .load      (go_data),
        .load_addr (load_addr),
        .arr_rdata (arr_rdata),
        .arr_rd    (arr_rd),
        .arr_addr  (arr_addr),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

endmodule

// File: rtl/dread_engine_chk.sv
// Port-level protocol checks for dread_engine, attached by bind.
module dread_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk_rise,
    input logic       sclk_fall,
    input logic [1:0] dq_oe,
    input logic [1:0] dq_out,
    input logic       arr_rd,
    input logic       cont_active
);

    // R6: enables can only turn on at a falling strobe.
    assert_oe_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && (dq_oe == 2'b00) && !sclk_fall) |=> (dq_oe == 2'b00));

    // R4: output pair changes only after a falling strobe.
    assert_out_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dq_out) |-> $past(sclk_fall));

    // R10: array read request is a single-cycle pulse.
    assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd |=> !arr_rd);

    // R7: flag moves only on a rising strobe or while deselected.
    assert_cont_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cont_active) |-> ($past(sclk_rise) || $past(cs_n)));

    // R9: flag cannot turn on while deselected.
    assert_cont_no_set_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cont_active) |=> !cont_active);

endmodule

bind dread_engine dread_engine_chk u_chk (.*);

// File: tb/tb_dread_engine.sv
`timescale 1ns/1ps
module tb_dread_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk_rise = 1'b0;
    logic        sclk_fall = 1'b0;
    logic        start_dout = 1'b0;
    logic        start_dio = 1'b0;
    logic [1:0]  dq_in = 2'b00;
    logic [1:0]  dq_out;
    logic [1:0]  dq_oe;
    logic        cont_active;
    logic        arr_rd;
    logic [15:0] arr_addr;
    logic [7:0]  arr_rdata = 8'h00;

    int n_chk = 0;
    int n_fail = 0;
    int rd_cnt = 0;
    bit exp_cont = 1'b0;

    always #2.5 clk = ~clk;

    dread_engine dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .start_dout(start_dout), .start_dio(start_dio),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .cont_active(cont_active),
        .arr_rd(arr_rd), .arr_addr(arr_addr), .arr_rdata(arr_rdata)
    );

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        logic [7:0] p;
        p = a[7:0] * 8'd37;
        return p ^ a[15:8] ^ 8'h5A;
    endfunction

    // Array model with one-cycle read latency.
    always @(posedge clk) if (arr_rd === 1'b1) arr_rdata <= mem_f(arr_addr);
    always @(posedge clk) if (arr_rd === 1'b1) rd_cnt <= rd_cnt + 1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One ignored falling strobe, then one rising strobe carrying d.
    task automatic edge_in(input logic [1:0] d);
        sclk_fall = 1'b1;
        @(negedge clk);
        sclk_fall = 1'b0;
        chk("R6", "oe during input phase", {30'd0, dq_oe}, 32'd0);
        repeat (3) @(negedge clk);
        dq_in = d;
        sclk_rise = 1'b1;
        @(negedge clk);
        sclk_rise = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic data_fall(output logic [1:0] pins, output logic [1:0] oe);
        sclk_fall = 1'b1;
        @(negedge clk);
        sclk_fall = 1'b0;
        pins = dq_out;
        oe = dq_oe;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_bytes(input string req, input logic [15:0] a, input int n);
        logic [1:0] p;
        logic [1:0] oe;
        logic [7:0] e;
        for (int b = 0; b < n; b++) begin
            e = mem_f(a + 16'(b));
            for (int k = 0; k < 4; k++) begin
                data_fall(p, oe);
                chk(req, "data pair R4", {30'd0, p}, {30'd0, e[7-2*k -: 2]});
                chk("R6", "oe during data", {30'd0, oe}, 32'd3);
            end
        end
    endtask

    task automatic end_txn(input int base, input int n);
        cs_n = 1'b1;
        #1;
        chk("R6", "oe release at deselect", {30'd0, dq_oe}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R10", "array reads per transaction", rd_cnt - base, n + 1);
    endtask

    task automatic dio_txn(input string req, input logic [23:0] a,
                           input logic [7:0] m, input int n, input bit use_op);
        int base;
        base = rd_cnt;
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        if (use_op) begin
            start_dio = 1'b1;
            @(negedge clk);
            start_dio = 1'b0;
            repeat (2) @(negedge clk);
        end
        for (int i = 11; i >= 0; i--) edge_in({a[2*i+1], a[2*i]});
        for (int i = 3; i >= 0; i--) edge_in({m[2*i+1], m[2*i]});
        chk("R6", "oe before first data fall", {30'd0, dq_oe}, 32'd0);
        read_bytes(req, a[15:0], n);
        end_txn(base, n);
        exp_cont = (m[5:4] == 2'b10);
        chk("R7 R8", "cont flag after mode byte", {31'd0, cont_active}, {31'd0, exp_cont});
    endtask

    task automatic dout_txn(input logic [23:0] a, input int n);
        int base;
        base = rd_cnt;
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        start_dout = 1'b1;
        @(negedge clk);
        start_dout = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 23; i >= 0; i--) edge_in({1'b1, a[i]});
        for (int i = 0; i < 8; i++) edge_in({1'b1, i[0]});
        chk("R3", "oe after dummy edges", {30'd0, dq_oe}, 32'd0);
        read_bytes("R3", a[15:0], n);
        end_txn(base, n);
        chk("R3", "cont flag untouched", {31'd0, cont_active}, {31'd0, exp_cont});
    endtask

    task automatic abort_txn(input int nedges, input bit use_op);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        if (use_op) begin
            start_dio = 1'b1;
            @(negedge clk);
            start_dio = 1'b0;
            repeat (2) @(negedge clk);
        end
        for (int j = 0; j < nedges; j++) edge_in(2'b10);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        exp_cont = 1'b0;
        chk("R9", "cont cleared by early deselect", {31'd0, cont_active}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R6", "reset oe", {30'd0, dq_oe}, 32'd0);
        chk("R10", "reset arr_rd", {31'd0, arr_rd}, 32'd0);
        chk("R9", "reset cont", {31'd0, cont_active}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R2 R4 R5: basic dual I/O read, four sequential bytes.
        dio_txn("R1 R2", 24'h12_3456, 8'h00, 4, 1'b1);
        // R3: dual-output read with pin 1 held high.
        dout_txn(24'h00_ABCD, 3);
        // R5: wrap at the top of the array, upper address bits ignored.
        dio_txn("R5", 24'hA5_FFFE, 8'h0F, 4, 1'b1);
        dout_txn(24'h7F_FFFF, 2);

        // R7 R8: every mode byte in succession; opcode only when flag clear.
        for (int m = 0; m < 256; m++)
            dio_txn("R8", {8'hC3, m[7:0], m[7:0] ^ 8'h96}, m[7:0], 1, !exp_cont);

        // R7: arm, then run opcode-free with multiple bytes.
        dio_txn("R7", 24'h00_1234, 8'hEF, 1, 1'b1);
        dio_txn("R7", 24'h00_8001, 8'h20, 3, 1'b0);
        // R9: abort during address phase of an opcode-free transaction.
        abort_txn(5, 1'b0);
        // R9: arm, then abort inside the mode phase.
        dio_txn("R7", 24'h00_4321, 8'h20, 1, 1'b1);
        abort_txn(14, 1'b0);
        dio_txn("R9", 24'h00_0100, 8'h00, 1, 1'b1);

        // R9: reset clears the armed flag.
        dio_txn("R7", 24'h00_0F0F, 8'h2A, 1, 1'b1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_cont = 1'b0;
        chk("R9", "cont after reset", {31'd0, cont_active}, 32'd0);
        dio_txn("R1", 24'h00_2468, 8'h01, 2, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule